// File: doc/BRIEF.md
# Modulo Interval Timer with Coherent Byte Access

This block is a 16-bit up-counter that advances on a one-cycle timer tick enable and returns to zero after it reaches a programmable modulo value. The wrap sets an overflow flag. An interrupt output follows that flag when the interrupt is enabled. All logic runs on one system clock.

A CPU reaches the block over an 8-bit register bus. Reading the count as two bytes always yields a consistent pair, because reading the high byte captures the low byte in a holding register. Writing a new modulo value as two bytes is treated as one update: once the high byte is written, overflow reporting is held off until the low byte follows. A self-clearing control bit restarts the count from zero.

Top module: `mod_interval_timer`

## Requirements
- R1: On a cycle with `tick` high and the count below the modulo value, the count rises by one at that clock edge. Without `tick` the count holds.
- R2: On a cycle with `tick` high and the count equal to the modulo value, the count becomes 0x0000 and the overflow flag (control byte bit 7) is set at that edge. A modulo value m therefore gives a period of m+1 ticks.
- R3: After system reset the count is 0x0000, the modulo value is 0xFFFF, and the flag, the interrupt enable and `irq` are all 0.
- R4: A write to the control byte (address 4) with bit 0 set clears the count at that edge, whatever `tick` does. Bit 0 always reads back as 0.
- R5: Writes to the counter byte addresses 0 (high) and 1 (low) leave the count unchanged.
- R6: A read of address 0 returns the live high byte and, unless a value is already held, captures the live low byte. While a value is held, later reads of address 0 do not refresh it, and a read of address 1 returns the held byte.
- R7: A read of address 1 releases the held value. When nothing is held, address 1 returns the live low byte.
- R8: A write to the modulo high byte (address 2) blocks both the setting of the flag and `irq` until the modulo low byte (address 3) is written. The count still wraps during that time.
- R9: Writing control bit 7 as 0 clears the flag only if a control read has returned the flag as 1 since the flag was set. A write without that read leaves the flag set.
- R10: `irq` is high exactly when the flag is 1, the interrupt enable (control bit 1) is 1, and no modulo update is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timer count enable |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (applies read side effects at the edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| irq | output | 1 | Interrupt request |

## Verification
`bus_rdata` depends combinationally on the address. Every read is therefore sampled 1 ns after the strobe is driven, before the edge that applies the read side effects. Each tick, write or read-release takes effect at the single clock edge that follows its strobe, so the bench sets up stimulus at the falling edge and checks state at the next falling edge or later. The wrap flag and `irq` are due at the same edge as the wrap itself. For each step of the modulo sweep, the expected count k mod (m+1) and the expected `irq` are compared one edge after that tick.

// File: rtl/mit_pkg.sv
package mit_pkg;
   localparam int unsigned ADDR_BITS = 3;
   localparam logic [ADDR_BITS-1:0] A_CNT_HI = 3'd0;
   localparam logic [ADDR_BITS-1:0] A_CNT_LO = 3'd1;
   localparam logic [ADDR_BITS-1:0] A_MOD_HI = 3'd2;
   localparam logic [ADDR_BITS-1:0] A_MOD_LO = 3'd3;
   localparam logic [ADDR_BITS-1:0] A_CTRL   = 3'd4;
   localparam int unsigned B_RESTART = 0;
   localparam int unsigned B_IRQ_EN  = 1;
   localparam int unsigned B_FLAG    = 7;
endpackage

// File: rtl/mit_counter.sv
module mit_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] mod_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_top;

   assign at_top = (cnt_q == mod_val);
   assign wrap   = tick && at_top && !restart;
   assign cnt    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart)   cnt_q <= '0;
      else if (tick) begin
         if (at_top)      cnt_q <= '0;
         else             cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(cnt_q));
   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && cnt_q != mod_val) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt_q == '0);
   assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt_q == '0);
endmodule

// File: rtl/mit_read_latch.sv
module mit_read_latch #(
   parameter int unsigned BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_hi,
   input  logic             rd_lo,
   input  logic [BUS_W-1:0] live_lo,
   output logic [BUS_W-1:0] lo_view
);
   logic             held_q;
   logic [BUS_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         hold_q <= '0;
      end else if (rd_lo) begin
         held_q <= 1'b0;
      end else if (rd_hi && !held_q) begin
         held_q <= 1'b1;
         hold_q <= live_lo;
      end
   end

   assign lo_view = held_q ? hold_q : live_lo;

   assert_no_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !rd_lo) |=> (held_q && $stable(hold_q)));
   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> !held_q);
endmodule

// File: rtl/mit_status.sv
module mit_status #(
   parameter bit CLR_AFTER_READ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic mod_hi_wr,
   input  logic mod_lo_wr,
   input  logic ctrl_rd,
   input  logic ctrl_wr,
   input  logic wr_flag_bit,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   logic flag_q, pend_q, clr_ok;

   generate
      if (CLR_AFTER_READ) begin : g_armed_clear
         logic armed_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                 armed_q <= 1'b0;
            else if (wrap && !pend_q)   armed_q <= 1'b0;
            else if (ctrl_rd)           armed_q <= flag_q;
            else if (ctrl_wr)           armed_q <= 1'b0;
         end
         assign clr_ok = ctrl_wr && !wr_flag_bit && armed_q;
      end else begin : g_plain_clear
         assign clr_ok = ctrl_wr && !wr_flag_bit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (mod_lo_wr)       pend_q <= 1'b0;
         else if (mod_hi_wr)  pend_q <= 1'b1;
         if (wrap && !pend_q) flag_q <= 1'b1;
         else if (clr_ok)     flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
   assign irq  = flag_q && irq_en && !pend_q;

   assert_inhibit_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> !$rose(flag_q));
   assert_wrap_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !pend_q) |=> flag_q);
   assert_clear_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !ctrl_wr) |=> flag_q);
endmodule

// File: rtl/mod_interval_timer.sv
module mod_interval_timer
   import mit_pkg::*;
#(
   parameter int unsigned BUS_W          = 8,
   parameter int unsigned CNT_W          = 16,
   parameter bit          CLR_AFTER_READ = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [ADDR_BITS-1:0] bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic                 irq
);
   localparam int unsigned HALF = CNT_W / 2;

   initial begin
      assert (CNT_W == 2 * BUS_W) else $error("counter must be two bus bytes");
      assert (BUS_W > B_FLAG) else $error("bus too narrow for control bits");
   end

   logic [CNT_W-1:0] mod_q, cnt;
   logic             ie_q, flag, wrap, restart;
   logic             wr_mhi, wr_mlo, wr_ctl, rd_chi, rd_clo, rd_ctl;
   logic [BUS_W-1:0] lo_view;

   assign wr_mhi  = bus_wr && bus_addr == A_MOD_HI;
   assign wr_mlo  = bus_wr && bus_addr == A_MOD_LO;
   assign wr_ctl  = bus_wr && bus_addr == A_CTRL;
   assign rd_chi  = bus_rd && bus_addr == A_CNT_HI;
   assign rd_clo  = bus_rd && bus_addr == A_CNT_LO;
   assign rd_ctl  = bus_rd && bus_addr == A_CTRL;
   assign restart = wr_ctl && bus_wdata[B_RESTART];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_q <= '1;
         ie_q  <= 1'b0;
      end else begin
         if (wr_mhi) mod_q[CNT_W-1:HALF] <= bus_wdata;
         if (wr_mlo) mod_q[HALF-1:0]     <= bus_wdata;
         if (wr_ctl) ie_q                <= bus_wdata[B_IRQ_EN];
      end
   end

   mit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .mod_val(mod_q), .cnt(cnt), .wrap(wrap)
   );

   mit_read_latch #(.BUS_W(BUS_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .rd_hi(rd_chi), .rd_lo(rd_clo),
      .live_lo(cnt[HALF-1:0]), .lo_view(lo_view)
   );

   mit_status #(.CLR_AFTER_READ(CLR_AFTER_READ)) u_stat (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .mod_hi_wr(wr_mhi),
      .mod_lo_wr(wr_mlo), .ctrl_rd(rd_ctl), .ctrl_wr(wr_ctl),
      .wr_flag_bit(bus_wdata[B_FLAG]), .irq_en(ie_q),
      .flag(flag), .irq(irq)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CNT_HI: bus_rdata = cnt[CNT_W-1:HALF];
         A_CNT_LO: bus_rdata = lo_view;
         A_MOD_HI: bus_rdata = mod_q[CNT_W-1:HALF];
         A_MOD_LO: bus_rdata = mod_q[HALF-1:0];
         A_CTRL: begin
            bus_rdata[B_FLAG]   = flag;
            bus_rdata[B_IRQ_EN] = ie_q;
         end
         default: bus_rdata = '0;
      endcase
   end

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie_q && flag));
   assert_ro_counter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr <= A_CNT_LO && !tick) |=> $stable(cnt));
endmodule

// File: tb/sim_mod_interval_timer.sv
module sim_mod_interval_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;
   int vecs = 0;
   int bad  = 0;

   always #5 clk = ~clk;

   mod_interval_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int got, input int exp);
      vecs++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(posedge clk);
         #1 tick = 1'b0;
      end
   endtask

   task automatic rd_count(output int v);
      logic [7:0] h, l;
      rd(3'd0, h);
      rd(3'd1, l);
      v = {h, l};
   endtask

   task automatic set_mod(input int m);
      logic [7:0] c;
      wr(3'd2, m[15:8]);
      wr(3'd3, m[7:0]);
      rd(3'd4, c);
      wr(3'd4, 8'h03);   // restart, irq enable, flag write 0
   endtask

   initial begin
      #3_000_000;
      bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int v;
      int mods [6] = '{0, 1, 2, 5, 12, 'h123};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R3 reset state
      rd_count(v);     chk("R3 count", v, 0);
      rd(3'd2, d);     chk("R3 mod hi", d, 8'hFF);
      rd(3'd3, d);     chk("R3 mod lo", d, 8'hFF);
      rd(3'd4, d);     chk("R3 ctrl", d, 0);
      chk("R3 irq", irq, 0);

      // R1 no tick, no motion
      repeat (5) @(posedge clk);
      rd_count(v);     chk("R1 idle", v, 0);

      // R1 R2 sweep over modulo values
      foreach (mods[i]) begin
         set_mod(mods[i]);
         for (int k = 1; k <= 2 * mods[i] + 3; k++) begin
            ticks(1);
            rd_count(v);
            chk("R2 count", v, k % (mods[i] + 1));
            chk("R10 irq", irq, (k > mods[i]) ? 1 : 0);
         end
      end

      // R4 restart bit
      set_mod(16'h00FF);
      ticks(7);
      wr(3'd4, 8'h03);
      rd_count(v);     chk("R4 cleared", v, 0);
      rd(3'd4, d);     chk("R4 bit0 reads 0", d[0], 0);
      @(negedge clk);
      tick = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h03; bus_wr = 1'b1;
      @(posedge clk); #1 tick = 1'b0; bus_wr = 1'b0;
      rd_count(v);     chk("R4 beats tick", v, 0);

      // R5 counter bytes are read-only
      ticks(9);
      wr(3'd0, 8'hAA);
      wr(3'd1, 8'h55);
      rd_count(v);     chk("R5 ignored", v, 9);

      // R6 R7 coherent read
      set_mod(16'hFFFF);
      ticks(255);
      rd(3'd0, d);     chk("R6 hi", d, 8'h00);
      ticks(3);
      rd(3'd0, d);     chk("R6 hi live", d, 8'h01);
      rd(3'd1, d);     chk("R6 held lo", d, 8'hFF);
      rd(3'd1, d);     chk("R7 live lo", d, 8'h02);
      ticks(1);
      rd(3'd1, d);     chk("R7 unheld lo", d, 8'h03);

      // R8 modulo update inhibits reporting
      set_mod(4);
      wr(3'd2, 8'h00);
      ticks(12);
      chk("R8 irq held off", irq, 0);
      rd(3'd4, d);     chk("R8 flag held off", d[7], 0);
      rd_count(v);     chk("R8 still wraps", v, 12 % 5);
      wr(3'd3, 8'h04);
      ticks(3);
      chk("R8 flag after lo", irq, 1);

      // R10 enable gating
      wr(3'd4, 8'h00);
      chk("R10 disabled", irq, 0);
      wr(3'd4, 8'h02);
      chk("R10 enabled", irq, 1);

      // R9 clear needs prior read
      wr(3'd4, 8'h02);
      chk("R9 blind clear", irq, 1);
      rd(3'd4, d);     chk("R9 ctrl", d, 8'h82);
      wr(3'd4, 8'h02);
      chk("R9 cleared irq", irq, 0);
      rd(3'd4, d);     chk("R9 cleared", d, 8'h02);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule